// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small processor, built as a microprogram sequencer. A 64-word microcode ROM sits behind a 6-bit microaddress register. Each ROM word carries three things:

- a next-address select code,
- an absolute target address,
- a horizontal micro-operation field whose bits drive the datapath control lines directly.

On every rising clock edge the sequencer picks the next microaddress from one of four sources. It can increment the current address, take the word's target address, map the 4-bit opcode to a block start, or make a jump that depends on the zero flag.

The microprogram is computed inside the RTL. It provides a two-state fetch routine, execute routines for sixteen opcodes, and conditional branch routines for both flag polarities. Each opcode maps to address `opcode*4`, so it owns four consecutive words. Opcode 0 maps onto the fetch routine itself and therefore acts as a no-op. The datapath, the main memory and any second-level nano-store lie outside this block.

The ROM is read synchronously with the next address. Because of this, the registered microinstruction always matches the word at the current microaddress, and the control outputs come straight from a register.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high `rst`, sampled at a rising edge, sets `uaddr` to 0 and `ctrl` to 16'h0003, which is the first fetch word. This holds from any state.
- R2: A microinstruction holds a select code (00 increment, 01 jump, 10 opcode map, 11 flag-conditional jump), a polarity bit, a 6-bit target, and a 16-bit micro-operation field that appears unchanged on `ctrl`. With select 01 the next address is the target.
- R3: With select 00 the next microaddress is the current one plus 1, modulo 64.
- R4: With select 10 the next microaddress is `{opcode, 2'b00}`, using the opcode present at that edge.
- R5: With select 11 and polarity 0, the next address is the target when `zero` is 1, and current+1 otherwise.
- R6: With select 11 and polarity 1, the next address is the target when `zero` is 0, and current+1 otherwise.
- R7: `opcode` affects only steps that use select 10, and `zero` affects only steps that use select 11. Outside those steps the address sequence and `ctrl` do not depend on them.
- R8: The fetch routine is as follows. Word 0 drives ctrl 16'h0003 (address-from-PC bit0, memory read bit1) and increments. Word 1 drives 16'h000C (PC increment bit2, instruction load bit3) and maps. Opcode 0 therefore returns to word 0.
- R9: For each opcode n from 1 to 7, there are two words. Word 4n drives 16'h0003 and increments. Word 4n+1 drives accumulator load (bit5), flag load (bit13) and the one-hot ALU bit 5+n, then jumps to 0.
- R10: Opcode 8 (word 32) drives PC load (16'h0010) and jumps to 0. Opcodes 11 to 15 (word 4n) drive memory write (16'h4000) and jump to 0. Every word not listed in R8 to R11 drives 0 and jumps to 0.
- R11: Opcode 9 (jump on zero) starts at word 36. That word drives 0 and is a conditional jump with polarity 0 and target 38. Word 37 drives 16'h0004 and word 38 drives 16'h0010, and both jump to 0. Opcode 10 (jump on nonzero) uses words 40, 41 and 42 in the same way, with polarity 1 and target 42.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Instruction register opcode bits |
| zero | input | 1 | Zero condition flag from the datapath |
| uaddr | output | 6 | Current microaddress |
| ctrl | output | 16 | Horizontal control signals of the current microinstruction |

## Verification
The hardest behaviour to exercise from the ports is R7. The opcode and the flag matter only at one edge each, so a design that samples them at the wrong cycle still looks correct when the inputs are held steady. To catch this, the stimulus drives the bit-inverted opcode and the inverted flag on every cycle except the single edge where the current word maps or branches. It then sweeps all sixteen opcodes against both flag values, and compares the microaddress and control vector at every step with a model computed in the bench.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OPC_W  = 4;
  localparam int PAD_W  = 2;
  localparam int ADDR_W = OPC_W + PAD_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CTRL_W = 16;
  localparam int ALU_LO = 5;

  typedef enum logic [1:0] {
    SEL_INC  = 2'b00,
    SEL_JMP  = 2'b01,
    SEL_MAP  = 2'b10,
    SEL_COND = 2'b11
  } sel_e;

  typedef struct packed {
    sel_e              sel;
    logic              inv;
    logic [ADDR_W-1:0] addr;
    logic [CTRL_W-1:0] uops;
  } uword_t;

  localparam logic [CTRL_W-1:0] U_AR_PC  = CTRL_W'(1) << 0;
  localparam logic [CTRL_W-1:0] U_RD     = CTRL_W'(1) << 1;
  localparam logic [CTRL_W-1:0] U_PC_INC = CTRL_W'(1) << 2;
  localparam logic [CTRL_W-1:0] U_IR_LD  = CTRL_W'(1) << 3;
  localparam logic [CTRL_W-1:0] U_PC_LD  = CTRL_W'(1) << 4;
  localparam logic [CTRL_W-1:0] U_ACC_LD = CTRL_W'(1) << 5;
  localparam logic [CTRL_W-1:0] U_FLG_LD = CTRL_W'(1) << 13;
  localparam logic [CTRL_W-1:0] U_WR     = CTRL_W'(1) << 14;

  localparam logic [OPC_W-1:0] OP_JMP  = OPC_W'(8);
  localparam logic [OPC_W-1:0] OP_JZ   = OPC_W'(9);
  localparam logic [OPC_W-1:0] OP_JNZ  = OPC_W'(10);
  localparam logic [OPC_W-1:0] OP_ALUH = OPC_W'(7);

  // Microprogram contents, computed from the address so no literal table exists.
  function automatic uword_t ucode_word(input logic [ADDR_W-1:0] a);
    uword_t w;
    logic [OPC_W-1:0] op;
    logic [PAD_W-1:0] slot;
    w.sel  = SEL_JMP;
    w.inv  = 1'b0;
    w.addr = '0;
    w.uops = '0;
    op   = a[ADDR_W-1:PAD_W];
    slot = a[PAD_W-1:0];
    if (op == '0) begin
      if (slot == PAD_W'(0)) begin
        w.sel = SEL_INC; w.uops = U_AR_PC | U_RD;
      end else if (slot == PAD_W'(1)) begin
        w.sel = SEL_MAP; w.uops = U_PC_INC | U_IR_LD;
      end
    end else if (op <= OP_ALUH) begin
      if (slot == PAD_W'(0)) begin
        w.sel = SEL_INC; w.uops = U_AR_PC | U_RD;
      end else if (slot == PAD_W'(1)) begin
        w.uops = U_ACC_LD | U_FLG_LD | (CTRL_W'(1) << (ALU_LO + int'(op)));
      end
    end else if (op == OP_JMP) begin
      if (slot == PAD_W'(0)) w.uops = U_PC_LD;
    end else if (op == OP_JZ || op == OP_JNZ) begin
      if (slot == PAD_W'(0)) begin
        w.sel  = SEL_COND;
        w.inv  = (op == OP_JNZ);
        w.addr = {op, PAD_W'(2)};
      end else if (slot == PAD_W'(1)) begin
        w.uops = U_PC_INC;
      end else if (slot == PAD_W'(2)) begin
        w.uops = U_PC_LD;
      end
    end else begin
      if (slot == PAD_W'(0)) w.uops = U_WR;
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output uword_t            q
);
  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = ucode_word(ADDR_W'(i));
  end

  // Synchronous read so the store maps onto a block RAM.
  always_ff @(posedge clk) begin
    q <= rom[rd_addr];
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] cur,
  input  uword_t            uir,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              zero,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] inc_addr;
  logic [ADDR_W-1:0] map_addr;
  logic              taken;

  assign inc_addr = cur + ADDR_W'(1);
  assign map_addr = {opcode, {PAD_W{1'b0}}};
  assign taken    = zero ^ uir.inv;

  always_comb begin
    unique case (uir.sel)
      SEL_INC:  nxt = inc_addr;
      SEL_JMP:  nxt = uir.addr;
      SEL_MAP:  nxt = map_addr;
      SEL_COND: nxt = taken ? uir.addr : inc_addr;
      default:  nxt = inc_addr;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              zero,
  output logic [ADDR_W-1:0] uaddr,
  output logic [CTRL_W-1:0] ctrl
);
  logic [ADDR_W-1:0] upc;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] load_addr;
  uword_t            uir;

  useq_next u_next (
    .cur    (upc),
    .uir    (uir),
    .opcode (opcode),
    .zero   (zero),
    .nxt    (nxt)
  );

  assign load_addr = rst ? '0 : nxt;

  useq_rom u_rom (
    .clk     (clk),
    .rd_addr (load_addr),
    .q       (uir)
  );

  always_ff @(posedge clk) begin
    upc <= load_addr;
  end

  assign uaddr = upc;
  assign ctrl  = uir.uops;

  p_reset_r1: assert property (@(posedge clk) rst |=> (upc == '0));
  p_jump_r2: assert property (@(posedge clk) disable iff (rst)
    (uir.sel == SEL_JMP) |=> (upc == $past(uir.addr)));
  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (uir.sel == SEL_INC) |=> (upc == $past(upc) + ADDR_W'(1)));
  p_map_r4: assert property (@(posedge clk) disable iff (rst)
    (uir.sel == SEL_MAP) |=> (upc == {$past(opcode), {PAD_W{1'b0}}}));
  p_cond_r5: assert property (@(posedge clk) disable iff (rst)
    (uir.sel == SEL_COND && !uir.inv) |=>
      (upc == ($past(zero) ? $past(uir.addr) : $past(upc) + ADDR_W'(1))));
  p_cond_r6: assert property (@(posedge clk) disable iff (rst)
    (uir.sel == SEL_COND && uir.inv) |=>
      (upc == (!$past(zero) ? $past(uir.addr) : $past(upc) + ADDR_W'(1))));
endmodule

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = '0;
  logic       zero = 1'b0;
  logic [5:0] uaddr;
  logic [15:0] ctrl;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  useq_ctrl u_useq_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
    .uaddr(uaddr), .ctrl(ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_ctrl(input int a);
    int op = a / 4;
    int s = a % 4;
    if (op == 0 && s == 0) return 16'h0003;
    if (op == 0 && s == 1) return 16'h000C;
    if (op >= 1 && op <= 7 && s == 0) return 16'h0003;
    if (op >= 1 && op <= 7 && s == 1) return 16'h2020 | (16'h1 << (5 + op));
    if (op == 8 && s == 0) return 16'h0010;
    if ((op == 9 || op == 10) && s == 1) return 16'h0004;
    if ((op == 9 || op == 10) && s == 2) return 16'h0010;
    if (op >= 11 && s == 0) return 16'h4000;
    return 16'h0000;
  endfunction

  function automatic int exp_next(input int a, input int op, input bit z);
    if (a == 0) return 1;
    if (a == 1) return op * 4;
    if (a >= 4 && a <= 28 && a % 4 == 0) return a + 1;
    if (a == 36) return z ? 38 : 37;
    if (a == 40) return z ? 41 : 42;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int op = 0; op < 16; op++) begin
      for (int zi = 0; zi < 2; zi++) begin
        int ea;
        int prev;
        string tag;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset addr", uaddr, 0);
        check("R1 reset ctrl", ctrl, 16'h0003);
        ea = 0;
        for (int step = 0; step < 8; step++) begin
          // R7: wrong values everywhere except the one edge that uses them
          opcode = (ea == 1) ? 4'(op) : ~4'(op);
          zero = (ea == 36 || ea == 40) ? zi[0] : ~zi[0];
          prev = ea;
          ea = exp_next(ea, op, zi[0]);
          @(posedge clk);
          @(negedge clk);
          if (prev == 1) tag = "R4 R7 R8";
          else if (prev == 36) tag = "R5 R7 R11";
          else if (prev == 40) tag = "R6 R7 R11";
          else if (prev == 0 || ea == prev + 1) tag = "R3 R9";
          else tag = "R2 R10";
          check({tag, " addr"}, uaddr, ea);
          check("R2 R8 R9 R10 R11 ctrl", ctrl, exp_ctrl(ea));
          if (ea == 0) break;
        end
      end
    end
    // R1: reset taken from the middle of an execute routine
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    opcode = 4'd5;
    repeat (3) @(negedge clk);
    check("R9 mid addr", uaddr, 21);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid reset addr", uaddr, 0);
    check("R1 mid reset ctrl", ctrl, 16'h0003);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule